// File: doc/BRIEF.md
# Line Pixel Region Tagger with Dark Clamp

This block sits behind the analogue-to-digital converter of one sensor output channel. It receives a stream of digitized pixel samples. A start-of-frame flag marks the first sample of a frame and an end-of-line flag marks the last sample of each line. The block counts rows and columns and labels every sample with a region tag: dummy, dark, buffer, active or overclock. The regions follow a fixed layout in which every count is a parameter.

Each line that carries image data also carries shielded dark columns, and these arrive before its active pixels. The block sums the central dark columns of such a line, divides the sum by the number of samples, and subtracts this black level from each active pixel of the same line. Results below zero are clamped to zero. All other samples leave the block unchanged, so that downstream logic can still average the overclock samples as an alternative black level. The output is one register stage behind the input and carries the tag, the corrected value and the row and column of the sample.

Top module: `pxr_line_clamp`

## Requirements
- R1: The first N_DUMMY samples of every line (columns 0 to N_DUMMY-1) carry tag 0 (dummy) in every row.
- R2: The next N_DARK columns carry tag 1 (dark) in every row.
- R3: In the N_BUFROW buffer rows that follow the top dark rows, and in the N_BUFROW buffer rows that precede the bottom dark rows, the columns between the dark columns and the overclock columns carry tag 2 (buffer). In active rows, the N_BUF columns right after the dark columns also carry tag 2.
- R4: In active rows, the N_ACT columns after the buffer columns carry tag 3 (active). Their output is the input minus the black level of the current line.
- R5: Columns past the last active column carry tag 4 (overclock). Rows past the bottom dark rows carry tag 4 on all columns past the dark columns.
- R6: The N_DARKROW rows at the top and at the bottom of the frame carry tag 1 on all columns past the dark columns, except the overclock columns. The first line after a start-of-frame is such a dark row.
- R7: The black level is the floor of the sum of the dark columns, excluding the N_EDGE columns at each end, divided by their count (20 by default). Only buffer and active rows feed it. The excluded edge columns have no effect on it.
- R8: An active pixel below the black level gives an output of 0 and does not wrap.
- R9: Samples that are not tagged active are output with their input value unchanged.
- R10: When a valid sample is accepted, the output stage is updated on the next clock edge. out_col counts from 0 at start-of-frame and after each end-of-line. out_row counts from 0 at start-of-frame and steps after each end-of-line. After reset, out_valid, out_tag and out_pix are 0.
- R11: A cycle with in_valid low advances neither counter and produces no output (out_valid low on the next cycle).
- R12: Within one line, the output tag never decreases from one valid sample to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Sample is the first of a frame |
| in_eol | input | 1 | Sample is the last of a line |
| in_data | input | DATA_W | Raw pixel value |
| out_valid | output | 1 | Output sample present |
| out_tag | output | 3 | Region tag: 0 dummy, 1 dark, 2 buffer, 3 active, 4 overclock |
| out_pix | output | DATA_W | Clamped active value, or raw value for other tags |
| out_col | output | COL_W | Column of the sample within its line |
| out_row | output | ROW_W | Row of the sample within its frame |

## Verification
The properties assume that every line is at least as long as the dummy, dark, buffer and active columns together. They also assume that the end-of-line flag sits on the last sample of a line and the start-of-frame flag only on the first sample of a frame, so that the dark columns of a line always come before its active pixels. The stimulus always sends complete lines of fixed length with the flags in those positions. Random idle cycles fall between samples. The data is random across the full range, mixed with lines whose dark columns are forced to extremes or to a flat level just at the active pixel values.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

   typedef enum logic [2:0] {
      RGN_DUMMY   = 3'd0,
      RGN_DARK    = 3'd1,
      RGN_BUFFER  = 3'd2,
      RGN_ACTIVE  = 3'd3,
      RGN_OVERCLK = 3'd4
   } rgn_e;

   typedef enum logic [1:0] {
      RZ_DARK   = 2'd0,
      RZ_BUFFER = 2'd1,
      RZ_ACTIVE = 2'd2,
      RZ_OVER   = 2'd3
   } rowz_e;

   localparam int TAG_W = 3;

endpackage

// File: rtl/pxr_position.sv
module pxr_position #(
   parameter int COL_W = 12,
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eol,
   output logic [COL_W-1:0] cur_col,
   output logic [ROW_W-1:0] cur_row
);

   localparam logic [COL_W-1:0] COL_MAX = '1;
   localparam logic [ROW_W-1:0] ROW_MAX = '1;

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;

   // a frame start forces both counters to zero for the marked sample
   assign cur_col = in_sof ? '0 : col_q;
   assign cur_row = in_sof ? '0 : row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (in_valid) begin
         if (in_eol) begin
            col_q <= '0;
            row_q <= (cur_row == ROW_MAX) ? cur_row : cur_row + 1'b1;
         end else begin
            col_q <= (cur_col == COL_MAX) ? cur_col : cur_col + 1'b1;
            row_q <= cur_row;
         end
      end
   end

endmodule

// File: rtl/pxr_region_map.sv
module pxr_region_map
   import pxr_pkg::*;
#(
   parameter int COL_W     = 12,
   parameter int ROW_W     = 12,
   parameter int N_DUMMY   = 11,
   parameter int N_DARK    = 22,
   parameter int N_EDGE    = 1,
   parameter int N_BUF     = 12,
   parameter int N_ACT     = 1648,
   parameter int N_DARKROW = 12,
   parameter int N_BUFROW  = 12,
   parameter int N_ACTROW  = 2472
) (
   input  logic [COL_W-1:0] cur_col,
   input  logic [ROW_W-1:0] cur_row,
   output logic [TAG_W-1:0] tag,
   output logic             ref_take,
   output logic             ref_last
);

   // column boundaries
   localparam int C_DARK0 = N_DUMMY;
   localparam int C_BUF0  = C_DARK0 + N_DARK;
   localparam int C_ACT0  = C_BUF0 + N_BUF;
   localparam int C_OVC0  = C_ACT0 + N_ACT;
   localparam int C_REF0  = C_DARK0 + N_EDGE;
   localparam int C_REF1  = C_BUF0 - N_EDGE;
   // row boundaries
   localparam int R_BUF0  = N_DARKROW;
   localparam int R_ACT0  = R_BUF0 + N_BUFROW;
   localparam int R_BUF1  = R_ACT0 + N_ACTROW;
   localparam int R_DARK1 = R_BUF1 + N_BUFROW;
   localparam int R_OVC0  = R_DARK1 + N_DARKROW;

   int    c_i, r_i;
   rowz_e rz;
   rgn_e  rgn;

   assign c_i = int'(cur_col);
   assign r_i = int'(cur_row);

   always_comb begin
      if (r_i >= R_OVC0)                         rz = RZ_OVER;
      else if (r_i < R_BUF0 || r_i >= R_DARK1)   rz = RZ_DARK;
      else if (r_i < R_ACT0 || r_i >= R_BUF1)    rz = RZ_BUFFER;
      else                                       rz = RZ_ACTIVE;
   end

   always_comb begin
      if (c_i < C_DARK0)       rgn = RGN_DUMMY;
      else if (c_i < C_BUF0)   rgn = RGN_DARK;
      else if (c_i >= C_OVC0)  rgn = RGN_OVERCLK;
      else begin
         unique case (rz)
            RZ_DARK:   rgn = RGN_DARK;
            RZ_BUFFER: rgn = RGN_BUFFER;
            RZ_OVER:   rgn = RGN_OVERCLK;
            default:   rgn = (c_i < C_ACT0) ? RGN_BUFFER : RGN_ACTIVE;
         endcase
      end
   end

   assign tag      = rgn;
   assign ref_take = (rz == RZ_BUFFER || rz == RZ_ACTIVE) &&
                     (c_i >= C_REF0) && (c_i < C_REF1);
   assign ref_last = ref_take && (c_i == C_REF1 - 1);

endmodule

// File: rtl/pxr_dark_level.sv
module pxr_dark_level #(
   parameter int DATA_W = 12,
   parameter int N_REF  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              line_start,
   input  logic              ref_take,
   input  logic              ref_last,
   output logic [DATA_W-1:0] level
);

   localparam int SUM_W   = DATA_W + $clog2(N_REF);
   localparam bit IS_POW2 = (N_REF & (N_REF - 1)) == 0;

   logic [SUM_W-1:0]  acc_q;
   logic [SUM_W-1:0]  total;
   logic [DATA_W-1:0] quotient;
   logic [DATA_W-1:0] level_q;

   assign total = (line_start ? '0 : acc_q) + SUM_W'(in_data);

   generate
      if (IS_POW2) begin : g_shift
         localparam int LG = $clog2(N_REF);
         assign quotient = DATA_W'(total >> LG);
      end else begin : g_recip
         // exact floor division: error term below N_REF, sum below 2**SUM_W
         localparam int              SHIFT  = SUM_W + $clog2(N_REF);
         localparam longint unsigned RECIP_L =
            ((64'd1 << SHIFT) + 64'(N_REF) - 64'd1) / 64'(N_REF);
         localparam int              RECIP_W = $clog2(RECIP_L + 64'd1);
         localparam int              PROD_W  = SUM_W + RECIP_W;
         localparam logic [RECIP_W-1:0] RECIP = RECIP_W'(RECIP_L);
         logic [PROD_W-1:0] prod;
         assign prod     = PROD_W'(total) * PROD_W'(RECIP);
         assign quotient = DATA_W'(prod >> SHIFT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         level_q <= '0;
      end else if (in_valid) begin
         if (ref_last) begin
            acc_q   <= '0;
            level_q <= quotient;
         end else if (ref_take) begin
            acc_q <= total;
         end else if (line_start) begin
            acc_q <= '0;
         end
      end
   end

   assign level = level_q;

endmodule

// File: rtl/pxr_line_clamp.sv
module pxr_line_clamp
   import pxr_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int COL_W     = 12,
   parameter int ROW_W     = 12,
   parameter int N_DUMMY   = 11,
   parameter int N_DARK    = 22,
   parameter int N_EDGE    = 1,
   parameter int N_BUF     = 12,
   parameter int N_ACT     = 1648,
   parameter int N_DARKROW = 12,
   parameter int N_BUFROW  = 12,
   parameter int N_ACTROW  = 2472
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eol,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [2:0]        out_tag,
   output logic [DATA_W-1:0] out_pix,
   output logic [COL_W-1:0]  out_col,
   output logic [ROW_W-1:0]  out_row
);

   localparam int N_REF     = N_DARK - 2 * N_EDGE;
   localparam int LINE_MIN  = N_DUMMY + N_DARK + N_BUF + N_ACT;
   localparam int FRAME_MIN = 2 * (N_DARKROW + N_BUFROW) + N_ACTROW;

   // elaboration-time parameter checks
   generate
      if (N_REF < 1) begin : g_bad_ref
         $error("dark columns must exceed the trimmed edges");
      end
      if (N_EDGE + N_BUF < 1) begin : g_bad_gap
         $error("level needs one sample between reference and active pixels");
      end
      if (LINE_MIN >= (1 << COL_W)) begin : g_bad_colw
         $error("COL_W too narrow for the line layout");
      end
      if (FRAME_MIN >= (1 << ROW_W)) begin : g_bad_roww
         $error("ROW_W too narrow for the frame layout");
      end
      if (DATA_W < 2 || DATA_W > 24) begin : g_bad_dw
         $error("DATA_W out of supported range");
      end
   endgenerate

   logic [COL_W-1:0]  cur_col;
   logic [ROW_W-1:0]  cur_row;
   logic [TAG_W-1:0]  tag;
   logic              ref_take, ref_last;
   logic [DATA_W-1:0] level;
   logic [DATA_W-1:0] corr;

   pxr_position #(
      .COL_W (COL_W),
      .ROW_W (ROW_W)
   ) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sof   (in_sof),
      .in_eol   (in_eol),
      .cur_col  (cur_col),
      .cur_row  (cur_row)
   );

   pxr_region_map #(
      .COL_W     (COL_W),
      .ROW_W     (ROW_W),
      .N_DUMMY   (N_DUMMY),
      .N_DARK    (N_DARK),
      .N_EDGE    (N_EDGE),
      .N_BUF     (N_BUF),
      .N_ACT     (N_ACT),
      .N_DARKROW (N_DARKROW),
      .N_BUFROW  (N_BUFROW),
      .N_ACTROW  (N_ACTROW)
   ) u_map (
      .cur_col  (cur_col),
      .cur_row  (cur_row),
      .tag      (tag),
      .ref_take (ref_take),
      .ref_last (ref_last)
   );

   pxr_dark_level #(
      .DATA_W (DATA_W),
      .N_REF  (N_REF)
   ) u_lvl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .line_start (cur_col == '0),
      .ref_take   (ref_take),
      .ref_last   (ref_last),
      .level      (level)
   );

   // clamp at zero for active pixels; everything else passes raw
   always_comb begin
      if (tag == RGN_ACTIVE)
         corr = (in_data > level) ? in_data - level : '0;
      else
         corr = in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_tag   <= '0;
         out_pix   <= '0;
         out_col   <= '0;
         out_row   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_tag <= tag;
            out_pix <= corr;
            out_col <= cur_col;
            out_row <= cur_row;
         end
      end
   end

endmodule

// File: rtl/pxr_line_clamp_chk.sv
module pxr_line_clamp_chk #(
   parameter int DATA_W  = 12,
   parameter int COL_W   = 12,
   parameter int N_DUMMY = 11,
   parameter int N_DARK  = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic [2:0]        out_tag,
   input logic [DATA_W-1:0] out_pix,
   input logic [COL_W-1:0]  out_col
);

   logic [2:0] last_tag;
   logic       seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_tag <= '0;
         seen     <= 1'b0;
      end else if (out_valid) begin
         last_tag <= out_tag;
         seen     <= 1'b1;
      end
   end

   p_out_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_dummy_cols_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'(out_col) < N_DUMMY) |-> out_tag == 3'd0);

   p_dark_cols_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'(out_col) >= N_DUMMY && int'(out_col) < N_DUMMY + N_DARK)
      |-> out_tag == 3'd1);

   p_no_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_tag != 3'd3 || out_pix <= $past(in_data)));

   p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_tag == 3'd3 || out_pix == $past(in_data)));

   p_tag_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen && out_col != '0) |-> out_tag >= last_tag);

endmodule

bind pxr_line_clamp pxr_line_clamp_chk #(
   .DATA_W  (DATA_W),
   .COL_W   (COL_W),
   .N_DUMMY (N_DUMMY),
   .N_DARK  (N_DARK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_tag   (out_tag),
   .out_pix   (out_pix),
   .out_col   (out_col)
);

// File: tb/sim_pxr_line_clamp.sv
module sim_pxr_line_clamp;

   localparam int DW = 12;
   localparam int ND = 11, NK = 22, NE = 1, NB = 12, NA = 16;
   localparam int NKR = 2, NBR = 1, NAR = 4;
   localparam int NOVC = 6;
   localparam int LINE = ND + NK + NB + NA + NOVC;
   localparam int ROWS = 2 * (NKR + NBR) + NAR + 1;
   localparam int NREF = NK - 2 * NE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [2:0]    out_tag;
   logic [DW-1:0] out_pix;
   logic [11:0]   out_col, out_row;

   always #5 clk = ~clk;

   pxr_line_clamp #(
      .DATA_W (DW), .COL_W (12), .ROW_W (12),
      .N_DUMMY (ND), .N_DARK (NK), .N_EDGE (NE), .N_BUF (NB), .N_ACT (NA),
      .N_DARKROW (NKR), .N_BUFROW (NBR), .N_ACTROW (NAR)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sof (in_sof),
      .in_eol (in_eol), .in_data (in_data), .out_valid (out_valid),
      .out_tag (out_tag), .out_pix (out_pix), .out_col (out_col), .out_row (out_row)
   );

   int n_chk = 0, n_bad = 0;
   int b_row = 0, b_col = 0, b_sum = 0, b_level = 0;
   bit pend_v = 0;
   int pend_tag, pend_pix, pend_row, pend_col, last_tag = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_tag(input int r, input int c);
      if (c < ND) return 0;                       // R1
      if (c < ND + NK) return 1;                  // R2
      if (c >= ND + NK + NB + NA) return 4;       // R5
      if (r >= 2 * (NKR + NBR) + NAR) return 4;   // R5 rows past the frame
      if (r < NKR || r >= NKR + 2 * NBR + NAR) return 1; // R6
      if (r < NKR + NBR || r >= NKR + NBR + NAR) return 2; // R3
      return (c < ND + NK + NB) ? 2 : 3;          // R3 / R4
   endfunction

   function automatic bit ref_col(input int r, input int c);
      return (r >= NKR) && (r < NKR + 2 * NBR + NAR) &&
             (c >= ND + NE) && (c < ND + NK - NE);
   endfunction

   function automatic int gen(input int mode, input int c);
      bit central = (c >= ND + NE) && (c < ND + NK - NE);
      bit edge_c  = (c >= ND) && (c < ND + NK) && !central;
      int rnd = int'($urandom_range(4095, 0));
      case (mode)
         1: return central ? 4095 : (edge_c ? 0 : rnd);
         2: return central ? 0 : (edge_c ? 4095 : rnd);
         3: return central ? 1000 : 999 + (c % 3);
         default: return rnd;
      endcase
   endfunction

   task automatic check_pending();
      string tr;
      string pr;
      check(out_valid === pend_v, pend_v ? "R10" : "R11", int'(out_valid), int'(pend_v));
      if (pend_v) begin
         case (pend_tag)
            0: tr = "R1";
            1: tr = (pend_col < ND + NK) ? "R2" : "R6";
            2: tr = "R3";
            3: tr = "R4";
            default: tr = "R5";
         endcase
         if (pend_tag == 3) pr = (pend_pix == 0) ? "R8" : "R4 R7";
         else pr = "R9";
         check(int'(out_tag) == pend_tag, tr, int'(out_tag), pend_tag);
         check(int'(out_pix) == pend_pix, pr, int'(out_pix), pend_pix);
         check(int'(out_row) == pend_row, "R10 row", int'(out_row), pend_row);
         check(int'(out_col) == pend_col, "R10 col", int'(out_col), pend_col);
         if (pend_col != 0)
            check(int'(out_tag) >= last_tag, "R12", int'(out_tag), last_tag);
         last_tag = int'(out_tag);
      end
   endtask

   task automatic cycle(input bit v, input bit s, input bit e, input int d);
      int r, c;
      @(negedge clk);
      check_pending();
      in_valid = v; in_sof = s; in_eol = e; in_data = DW'(d);
      pend_v = v;
      if (v) begin
         r = s ? 0 : b_row;
         c = s ? 0 : b_col;
         if (c == 0) b_sum = 0;
         if (ref_col(r, c)) begin
            b_sum += d;
            if (c == ND + NK - NE - 1) b_level = b_sum / NREF; // R7 floor
         end
         pend_tag = exp_tag(r, c);
         pend_pix = (pend_tag == 3) ? ((d > b_level) ? d - b_level : 0) : d;
         pend_row = r;
         pend_col = c;
         if (e) begin b_col = 0; b_row = r + 1; end
         else begin b_col = c + 1; b_row = r; end
      end
   endtask

   task automatic send_line(input int mode, input bit first, input bit gaps);
      for (int c = 0; c < LINE; c++) begin
         if (gaps && $urandom_range(7, 0) == 0) cycle(0, 0, 0, 0); // R11 idle
         cycle(1, first && c == 0, c == LINE - 1, gen(mode, c));
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
      check(out_tag == 3'd0, "R10 reset tag", int'(out_tag), 0);
      check(out_pix == '0, "R10 reset pix", int'(out_pix), 0);
      rst_n = 1'b1;
      // frame 1: random data with idle gaps
      for (int r = 0; r < ROWS; r++) send_line(0, r == 0, 1'b1);
      // frame 2: directed dark levels (R7, R8) rotating per line
      for (int r = 0; r < ROWS; r++) send_line(1 + (r % 3), r == 0, 1'b0);
      // frame 3: restart mid-frame after a partial frame, random data
      for (int r = 0; r < 4; r++) send_line(0, r == 0, 1'b1);
      for (int r = 0; r < ROWS; r++) send_line(r % 2 == 0 ? 0 : 3, r == 0, 1'b1);
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule